// File: doc/BRIEF.md
# CAN Error Confinement and Status Tracker

This block keeps the two fault counters of a CAN-style node and works out the node's confinement state from them. The protocol engine sends it single-cycle event pulses: transmit error, successful transmit, receive error, successful receive, and bus-off recovery finished. From these the block moves the counters and produces three status levels: error warning, error passive and bus-off.

A warning threshold can be programmed and comes out of reset at 96. A listen-only input freezes the receive counter. Every accepted error also records its 2-bit type and the direction it occurred in.

Three latched interrupt flags are kept: warning change, passive change and bus error. Each has its own enable bit. A single acknowledge pulse clears all three flags, but a flag event arriving in the same cycle as the acknowledge keeps its flag set.

Top module: `can_fault_confine`

## Requirements
- R1: After reset both counters are 0, all status outputs are 0, all interrupt flags are 0, the captured error type and direction are 0, and the warning threshold is 96.
- R2: Outside bus-off, a transmit error adds 8 to the transmit counter and a successful transmit subtracts 1, stopping at 0. When both pulses arrive in the same cycle, only the error counts.
- R3: Outside bus-off, a receive error adds 1 to the receive counter, stopping at 255, and a successful receive subtracts 1, stopping at 0. When both pulses arrive in the same cycle, only the error counts. While listenOnly is 1, the receive counter does not change.
- R4: errWarn is 1 exactly when either counter is greater than or equal to the threshold. A cycle with limitWr=1 loads limitData as the new threshold.
- R5: errPassive is 1 exactly when busOff is 0 and either counter is 128 or more.
- R6: A transmit error that would take the transmit counter above 255 sets busOff and holds the counter at 255. While in bus-off, every event pulse is ignored except recoverDone. recoverDone clears both counters and busOff. recoverDone has no effect outside bus-off.
- R7: An accepted error pulse stores errType (00 bit, 01 form, 10 stuff, 11 other) in lastErrType. It stores lastErrDir=1 for a receive error and 0 for a transmit error. When both errors arrive together, the transmit error wins.
- R8: intRaw[0] (warning) sets one cycle after errWarn or busOff changes, in either direction.
- R9: intRaw[1] (passive) sets one cycle after errPassive changes, in either direction.
- R10: intRaw[2] (bus error) sets on the same clock edge that accepts an error pulse.
- R11: intAck clears all intRaw bits on the next edge. A bit whose set event happens on that same edge stays 1.
- R12: irq is 1 exactly when some bit of intRaw is 1 and its matching bit in intEnable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txErrPulse | input | 1 | Transmit error event |
| txOkPulse | input | 1 | Successful transmit event |
| rxErrPulse | input | 1 | Receive error event |
| rxOkPulse | input | 1 | Successful receive event |
| recoverDone | input | 1 | Bus-off recovery finished |
| errType | input | 2 | Type of the error that comes with an error pulse |
| listenOnly | input | 1 | Freezes the receive counter |
| limitWr | input | 1 | Load strobe for the warning threshold |
| limitData | input | 8 | New warning threshold |
| intEnable | input | 3 | Per-flag interrupt enables |
| intAck | input | 1 | Clears the interrupt flags |
| txErrCnt | output | 8 | Transmit error counter |
| rxErrCnt | output | 8 | Receive error counter |
| errWarn | output | 1 | Some counter is at or above the threshold |
| errPassive | output | 1 | Node is error-passive |
| busOff | output | 1 | Node is bus-off |
| intRaw | output | 3 | Latched interrupt flags: warning, passive, bus error |
| irq | output | 1 | Enabled interrupt request |
| lastErrType | output | 2 | Type of the last accepted error |
| lastErrDir | output | 1 | Direction of the last accepted error |

## Verification
The bench targets the following corner cases:
- A transmit counter of 247 that steps to exactly 255 without going bus-off, and then enters bus-off on the next error. An off-by-one overflow test would trip one step too early.
- Event pulses that arrive during bus-off and must leave the counters and the captured error untouched.
- recoverDone given outside bus-off, which must not clear anything.
- Warning and passive interrupts on falling transitions as well as rising ones. An edge detector that sees only one direction would miss half of them.
- Counter floors and ceilings, listen-only freezing, and an acknowledge in the same cycle as a bus error. A design that let the clear win would lose that interrupt.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  localparam int NUM_INT  = 3;
  localparam int INT_WARN = 0;
  localparam int INT_PASS = 1;
  localparam int INT_BERR = 2;

  typedef struct packed {
    logic txAdd;
    logic txSub;
    logic rxAdd;
    logic rxSub;
    logic recover;
    logic capture;
    logic capDir;
  } fcStrobe_t;
endpackage

// File: rtl/can_fc_dpath.sv
module can_fc_dpath
  import can_fc_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int TX_STEP   = 8,
  parameter int PASS_LVL  = 128,
  parameter int LIMIT_RST = 96
) (
  input  logic             clk,
  input  logic             rstN,
  input  fcStrobe_t        stb,
  input  logic [1:0]       errType,
  input  logic             limitWr,
  input  logic [CNT_W-1:0] limitData,
  output logic [CNT_W-1:0] tec,
  output logic [CNT_W-1:0] rec,
  output logic             busOffQ,
  output logic             warnFlag,
  output logic             passFlag,
  output logic [1:0]       lastType,
  output logic             lastDir
);
  localparam logic [CNT_W-1:0] PASS_V = CNT_W'(PASS_LVL);
  localparam logic [CNT_W-1:0] LIM_V  = CNT_W'(LIMIT_RST);
  localparam logic [CNT_W:0]   STEP_V = (CNT_W+1)'(TX_STEP);

  logic [CNT_W-1:0] limitQ;
  logic [CNT_W:0]   tecSum;

  assign tecSum = {1'b0, tec} + STEP_V;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tec     <= '0;
      rec     <= '0;
      busOffQ <= 1'b0;
    end else if (stb.recover) begin
      tec     <= '0;
      rec     <= '0;
      busOffQ <= 1'b0;
    end else begin
      if (stb.txAdd) begin
        if (tecSum[CNT_W]) begin
          tec     <= '1;
          busOffQ <= 1'b1;
        end else begin
          tec <= tecSum[CNT_W-1:0];
        end
      end else if (stb.txSub && tec != '0) begin
        tec <= tec - 1'b1;
      end
      if (stb.rxAdd) begin
        if (rec != '1) rec <= rec + 1'b1;
      end else if (stb.rxSub && rec != '0) begin
        rec <= rec - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      limitQ   <= LIM_V;
      lastType <= 2'b00;
      lastDir  <= 1'b0;
    end else begin
      if (limitWr) limitQ <= limitData;
      if (stb.capture) begin
        lastType <= errType;
        lastDir  <= stb.capDir;
      end
    end
  end

  assign warnFlag = (tec >= limitQ) || (rec >= limitQ);
  assign passFlag = !busOffQ && ((tec >= PASS_V) || (rec >= PASS_V));
endmodule

// File: rtl/can_fc_ctrl.sv
module can_fc_ctrl
  import can_fc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               txErrPulse,
  input  logic               txOkPulse,
  input  logic               rxErrPulse,
  input  logic               rxOkPulse,
  input  logic               recoverDone,
  input  logic               listenOnly,
  input  logic               busOffQ,
  input  logic               warnFlag,
  input  logic               passFlag,
  input  logic [NUM_INT-1:0] intEnable,
  input  logic               intAck,
  output fcStrobe_t          stb,
  output logic [NUM_INT-1:0] intRaw,
  output logic               irq
);
  logic live;
  logic warnPrev, boPrev, passPrev;
  logic [NUM_INT-1:0] setVec;

  assign live = !busOffQ;

  always_comb begin
    stb.txAdd   = live && txErrPulse;
    stb.txSub   = live && txOkPulse && !txErrPulse;
    stb.rxAdd   = live && !listenOnly && rxErrPulse;
    stb.rxSub   = live && !listenOnly && rxOkPulse && !rxErrPulse;
    stb.recover = busOffQ && recoverDone;
    stb.capture = live && (txErrPulse || rxErrPulse);
    stb.capDir  = !txErrPulse;
  end

  always_comb begin
    setVec           = '0;
    setVec[INT_WARN] = (warnFlag != warnPrev) || (busOffQ != boPrev);
    setVec[INT_PASS] = passFlag != passPrev;
    setVec[INT_BERR] = stb.capture;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      warnPrev <= 1'b0;
      boPrev   <= 1'b0;
      passPrev <= 1'b0;
      intRaw   <= '0;
    end else begin
      warnPrev <= warnFlag;
      boPrev   <= busOffQ;
      passPrev <= passFlag;
      intRaw   <= setVec | (intAck ? '0 : intRaw);
    end
  end

  assign irq = |(intRaw & intEnable);
endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine
  import can_fc_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int TX_STEP   = 8,
  parameter int PASS_LVL  = 128,
  parameter int LIMIT_RST = 96
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txErrPulse,
  input  logic               txOkPulse,
  input  logic               rxErrPulse,
  input  logic               rxOkPulse,
  input  logic               recoverDone,
  input  logic [1:0]         errType,
  input  logic               listenOnly,
  input  logic               limitWr,
  input  logic [CNT_W-1:0]   limitData,
  input  logic [NUM_INT-1:0] intEnable,
  input  logic               intAck,
  output logic [CNT_W-1:0]   txErrCnt,
  output logic [CNT_W-1:0]   rxErrCnt,
  output logic               errWarn,
  output logic               errPassive,
  output logic               busOff,
  output logic [NUM_INT-1:0] intRaw,
  output logic               irq,
  output logic [1:0]         lastErrType,
  output logic               lastErrDir
);
  fcStrobe_t stb;

  can_fc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .txErrPulse(txErrPulse), .txOkPulse(txOkPulse),
    .rxErrPulse(rxErrPulse), .rxOkPulse(rxOkPulse),
    .recoverDone(recoverDone), .listenOnly(listenOnly),
    .busOffQ(busOff), .warnFlag(errWarn), .passFlag(errPassive),
    .intEnable(intEnable), .intAck(intAck),
    .stb(stb), .intRaw(intRaw), .irq(irq)
  );

  can_fc_dpath #(
    .CNT_W(CNT_W), .TX_STEP(TX_STEP),
    .PASS_LVL(PASS_LVL), .LIMIT_RST(LIMIT_RST)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .errType(errType),
    .limitWr(limitWr), .limitData(limitData),
    .tec(txErrCnt), .rec(rxErrCnt), .busOffQ(busOff),
    .warnFlag(errWarn), .passFlag(errPassive),
    .lastType(lastErrType), .lastDir(lastErrDir)
  );
endmodule

// File: rtl/can_fc_chk.sv
module can_fc_chk #(
  parameter int CNT_W   = 8,
  parameter int TX_STEP = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             txErrPulse,
  input logic             recoverDone,
  input logic             listenOnly,
  input logic             intAck,
  input logic             rxErrPulse,
  input logic [CNT_W-1:0] txErrCnt,
  input logic [CNT_W-1:0] rxErrCnt,
  input logic             errWarn,
  input logic             errPassive,
  input logic             busOff,
  input logic [2:0]       intRaw
);
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(TX_STEP);
  localparam logic [CNT_W-1:0] TOP_V  = '1;

  // R2
  tx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busOff && txErrPulse && (txErrCnt <= TOP_V - STEP_V))
      |=> (txErrCnt == $past(txErrCnt) + STEP_V));

  // R3
  listen_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (listenOnly && !busOff) |=> $stable(rxErrCnt));

  // R6
  busoff_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busOff && !recoverDone) |=> ($stable(txErrCnt) && $stable(rxErrCnt) && busOff));

  // R6
  recover_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busOff && recoverDone) |=> (txErrCnt == '0 && rxErrCnt == '0 && !busOff));

  // R8
  warn_int_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((errWarn != $past(errWarn)) || (busOff != $past(busOff))) |=> intRaw[0]);

  // R9
  pass_int_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errPassive != $past(errPassive)) |=> intRaw[1]);

  // R11
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !txErrPulse && !rxErrPulse) |=> !intRaw[2]);
endmodule

bind can_fault_confine can_fc_chk #(.CNT_W(CNT_W), .TX_STEP(TX_STEP)) chk_i (.*);

// File: tb/can_fault_confine_tb_top.sv
module can_fault_confine_tb_top;
  logic clk = 1'b0;
  logic rstN;
  logic txErrPulse, txOkPulse, rxErrPulse, rxOkPulse, recoverDone;
  logic [1:0] errType;
  logic listenOnly, limitWr, intAck;
  logic [7:0] limitData;
  logic [2:0] intEnable;
  logic [7:0] txErrCnt, rxErrCnt;
  logic errWarn, errPassive, busOff, irq, lastErrDir;
  logic [2:0] intRaw;
  logic [1:0] lastErrType;

  int testCnt = 0;
  int failCnt = 0;

  always #10 clk = ~clk;

  can_fault_confine dut_i (.*);

  // {txErr, txOk, rxErr, rxOk}, expected tx count, expected rx count
  localparam logic [19:0] VEC [10] = '{
    20'h8_08_00, 20'h8_10_00, 20'h4_0F_00, 20'hC_17_00, 20'h2_17_01,
    20'h1_17_00, 20'h1_17_00, 20'h3_17_01, 20'hF_1F_02, 20'h4_1E_02
  };

  task automatic chk(input string req, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic te, input logic to, input logic re, input logic ro);
    txErrPulse = te; txOkPulse = to; rxErrPulse = re; rxOkPulse = ro;
    @(negedge clk);
    txErrPulse = 0; txOkPulse = 0; rxErrPulse = 0; rxOkPulse = 0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic ack();
    intAck = 1; @(negedge clk); intAck = 0;
  endtask

  task automatic doReset();
    rstN = 0; @(negedge clk); @(negedge clk); rstN = 1; @(negedge clk);
  endtask

  initial begin
    #4000000;
    failCnt++;
    $display("FAIL watchdog R1: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    txErrPulse = 0; txOkPulse = 0; rxErrPulse = 0; rxOkPulse = 0;
    recoverDone = 0; errType = 0; listenOnly = 0; limitWr = 0;
    limitData = 0; intAck = 0; intEnable = 0;
    rstN = 0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    rstN = 1; @(negedge clk);

    chk("R1 tec", txErrCnt, 0); chk("R1 rec", rxErrCnt, 0);
    chk("R1 status", {errWarn, errPassive, busOff}, 0);
    chk("R1 intRaw", intRaw, 0); chk("R1 irq", irq, 0);
    chk("R1 capture", {lastErrType, lastErrDir}, 0);

    // R2 / R3 vector walk
    for (int i = 0; i < 10; i++) begin
      pulse(VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16]);
      chk("R2 tec vec", txErrCnt, VEC[i][15:8]);
      chk("R3 rec vec", rxErrCnt, VEC[i][7:0]);
    end

    // R4 default threshold 96, R8 both directions
    doReset();
    for (int i = 0; i < 11; i++) pulse(1, 0, 0, 0);
    chk("R4 tec 88", txErrCnt, 88); chk("R4 warn below", errWarn, 0);
    chk("R1 threshold 96 not reached", errWarn, 0);
    idle(); ack();
    pulse(1, 0, 0, 0);
    chk("R4 warn at 96", errWarn, 1);
    idle(); chk("R8 warn rise", intRaw[0], 1);
    ack(); chk("R11 ack clears", intRaw, 0);
    pulse(0, 1, 0, 0);
    chk("R4 warn at 95", errWarn, 0);
    idle(); chk("R8 warn fall", intRaw[0], 1);

    // R5 / R9
    ack();
    for (int i = 0; i < 5; i++) pulse(1, 0, 0, 0);
    chk("R5 passive at 135", errPassive, 1);
    idle(); chk("R9 passive rise", intRaw[1], 1);
    ack();
    for (int i = 0; i < 8; i++) pulse(0, 1, 0, 0);
    chk("R5 active at 127", errPassive, 0);
    idle(); chk("R9 passive fall", intRaw[1], 1);

    // R10 / R12
    ack();
    intEnable = 3'b011;
    pulse(1, 0, 0, 0);
    chk("R10 berr set", intRaw, 3'b100);
    chk("R12 masked", irq, 0);
    intEnable = 3'b100; #1;
    chk("R12 enabled", irq, 1);

    // R11: set wins against ack
    intAck = 1; pulse(1, 0, 0, 0); intAck = 0;
    chk("R11 set wins", intRaw[2], 1);
    ack(); chk("R11 lone ack", intRaw, 0);

    // R7 capture
    errType = 2'b10; pulse(0, 0, 1, 0);
    chk("R7 rx type", lastErrType, 2); chk("R7 rx dir", lastErrDir, 1);
    errType = 2'b01; pulse(1, 0, 1, 0);
    chk("R7 tx wins type", lastErrType, 1); chk("R7 tx wins dir", lastErrDir, 0);
    errType = 2'b00;

    // R3 listen-only
    chk("R3 rec pre", rxErrCnt, 2);
    listenOnly = 1;
    pulse(0, 0, 1, 0); chk("R3 listen rxErr", rxErrCnt, 2);
    pulse(0, 0, 0, 1); chk("R3 listen rxOk", rxErrCnt, 2);
    listenOnly = 0;
    pulse(0, 0, 0, 1); chk("R3 resume", rxErrCnt, 1);

    // R3 ceiling
    doReset();
    for (int i = 0; i < 260; i++) pulse(0, 0, 1, 0);
    chk("R3 rec ceiling", rxErrCnt, 255);
    chk("R5 passive by rec", errPassive, 1);

    // R6 bus-off boundary
    doReset();
    for (int i = 0; i < 31; i++) pulse(1, 0, 0, 0);
    chk("R6 tec 248", txErrCnt, 248);
    pulse(0, 1, 0, 0);
    pulse(1, 0, 0, 0);
    chk("R6 tec 255 exact", txErrCnt, 255); chk("R6 not yet off", busOff, 0);
    idle(); ack();
    pulse(1, 0, 0, 0);
    chk("R6 enter off", busOff, 1); chk("R6 tec held", txErrCnt, 255);
    chk("R5 no passive in off", errPassive, 0);
    idle(); chk("R8 busoff change", intRaw[0], 1);
    errType = 2'b11;
    pulse(0, 1, 1, 0);
    pulse(0, 0, 0, 1);
    chk("R6 ignored tec", txErrCnt, 255); chk("R6 ignored rec", rxErrCnt, 0);
    chk("R6 ignored capture", lastErrType, 0);
    errType = 2'b00;
    recoverDone = 1; idle(); recoverDone = 0;
    chk("R6 recover tec", txErrCnt, 0); chk("R6 recover off", busOff, 0);
    pulse(1, 0, 0, 0);
    recoverDone = 1; idle(); recoverDone = 0;
    chk("R6 recover outside off", txErrCnt, 8);

    // R4 threshold write
    limitData = 8'd10; limitWr = 1; idle(); limitWr = 0;
    chk("R4 limit 10 below", errWarn, 0);
    pulse(1, 0, 0, 0);
    chk("R4 limit 10 above", errWarn, 1);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule